// File: doc/BRIEF.md
# External Interrupt Request Controller

This block collects external interrupt requests from port pins and places them on two interrupt vectors for the CPU sequencer. Vector 1 has a single dedicated pin. It can be set up as a falling-edge latch or as a low-level request that is re-evaluated at every instruction boundary. Vector 2 merges a parameterizable group of pins onto one shared line. It detects a single selectable edge on that line and holds at most one request.

The sequencer reads a pending flag for each vector and a vector index. It confirms the start of each service routine with an acknowledge pulse. A wake output lets a processor in the stop state resume whenever a request is pending. Every pin goes through a synchronizer before it is used. The per-pin enables and the configuration bits come from logic in the same clock domain and act immediately.

The vector 2 merge is modelled as it is in hardware. A pin that sits at the active level hides edges on its neighbours. Changing the polarity or the pin enables can produce an edge on the merged line, and that edge is latched like a real one.

Top module: `eirq_ctrl`

## Requirements
- R1: `vec_valid` is high exactly when `cfg_gen` is 1 and at least one vector is pending. With `cfg_gen` at 0, no vector is offered, but the pending latches keep their state.
- R2: When a vector is offered, `vec_idx` is 2'd1 if vector 1 is pending and 2'd2 if only vector 2 is pending. Vector 1 has priority.
- R3: With `cfg_v1_level` = 0 (edge mode), a falling transition on the synchronized `v1_pin` sets `pend_v1`.
- R4: An acknowledge pulse (`ack_v1` or `ack_v2`) clears the matching edge latch on the next clock edge. A new edge in the same cycle wins and keeps the latch set.
- R5: Each vector stores at most one request. Edges that arrive while its latch is already set are absorbed, so one acknowledge leaves it clear.
- R6: With `cfg_v1_level` = 1 (level mode), `pend_v1` equals the inverse of the synchronized `v1_pin` as captured at the most recent `sample_stb`. A low pulse between two strobes leaves no request, and the edge latch is held clear.
- R7: `wake` is high whenever `pend_v1` or `pend_v2` is high, whatever the value of `cfg_gen`.
- R8: For the vector 2 merge, a pin whose `v2_irq_en` bit is 0 counts as 1. With `cfg_v2_rise` = 0 the shared line is the AND of the pin values and the request fires on its fall. With `cfg_v2_rise` = 1 it is the OR and fires on its rise. As a result, one pin held at the active level blocks requests from the other pins.
- R9: `cfg_v2_rise` selects the vector 2 active edge (0 = falling, 1 = rising). Toggling it while the pins are static sets `pend_v2` whenever the polarity-adjusted line becomes active.
- R10: A change in `v2_irq_en` that makes the polarity-adjusted line active sets `pend_v2`. Two cases do this: enabling a pin that reads 0 under falling polarity, and disabling a pin that reads 0 under rising polarity while the other enabled pins read 0.
- R11: A pin change shows on a pending flag at the third rising clock edge after it is applied (two synchronizer stages plus the latch). A configuration or enable change shows at the first rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gen | input | 1 | Global enable for offering vectors |
| cfg_v1_level | input | 1 | Vector 1 mode: 1 = level, 0 = falling edge |
| cfg_v2_rise | input | 1 | Vector 2 polarity: 1 = rising, 0 = falling |
| v1_pin | input | 1 | Vector 1 source pin (asynchronous) |
| v2_pins | input | NPIN | Vector 2 source pins (asynchronous) |
| v2_irq_en | input | NPIN | Per-pin interrupt enable for vector 2 |
| sample_stb | input | 1 | Instruction-boundary strobe, used for level sampling |
| ack_v1 | input | 1 | Service routine for vector 1 started |
| ack_v2 | input | 1 | Service routine for vector 2 started |
| pend_v1 | output | 1 | Vector 1 request pending |
| pend_v2 | output | 1 | Vector 2 request pending |
| wake | output | 1 | Leave the stop state |
| vec_valid | output | 1 | A vector is offered to the sequencer |
| vec_idx | output | 2 | Offered vector number (1 or 2) |

## Verification
The bench builds the block with NPIN = 3 and two synchronizer stages. Random pin and enable patterns then cover all eight vector 2 input combinations many times, under both polarities. This is enough to show blocking by a stuck pin, unblocking after it releases, and false edges caused by enable or polarity changes. Directed sequences check the exact latency, level-mode sampling, priority and acknowledge behaviour.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    typedef enum logic [1:0] {
        VEC_NONE = 2'd0,
        VEC_ONE  = 2'd1,
        VEC_TWO  = 2'd2
    } vec_e;

    typedef struct packed {
        logic pend;
    } latch_st_t;

    typedef struct packed {
        logic act;
    } merge_st_t;

    typedef struct packed {
        logic prev;
        logic lvl_req;
    } v1_st_t;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int WIDTH   = 4,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam logic [WIDTH-1:0] RESET_WORD = {WIDTH{RST_VAL}};

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_comb begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_WORD}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_merge.sv
module eirq_merge
    import eirq_pkg::*;
#(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins,
    input  logic [NPIN-1:0] en,
    input  logic            rise,
    output logic            edge_hit
);
    merge_st_t st_d, st_q;
    logic [NPIN-1:0] eff;
    logic            act_now;

    always_comb begin
        // a pin out of interrupt mode reads as idle-high on the shared line
        eff      = pins | ~en;
        act_now  = rise ? (|eff) : ~(&eff);
        st_d.act = act_now;
        edge_hit = act_now & ~st_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch
    import eirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic kill,
    output logic pend
);
    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kill)     st_d.pend = 1'b0;
        else if (set) st_d.pend = 1'b1;
        else if (clr) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/eirq_v1.sv
module eirq_v1
    import eirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic level_mode,
    input  logic strobe,
    input  logic ack,
    output logic pend
);
    v1_st_t st_d, st_q;
    logic   fall_hit;
    logic   edge_pend;

    always_comb begin
        st_d      = st_q;
        st_d.prev = line;
        fall_hit  = st_q.prev & ~line;
        if (!level_mode)  st_d.lvl_req = 1'b0;
        else if (strobe)  st_d.lvl_req = ~line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1, lvl_req: 1'b0};
        else        st_q <= st_d;
    end

    eirq_latch i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (~level_mode & fall_hit),
        .clr  (ack),
        .kill (level_mode),
        .pend (edge_pend)
    );

    assign pend = level_mode ? st_q.lvl_req : edge_pend;
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
    import eirq_pkg::*;
#(
    parameter int NPIN        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_gen,
    input  logic            cfg_v1_level,
    input  logic            cfg_v2_rise,
    input  logic            v1_pin,
    input  logic [NPIN-1:0] v2_pins,
    input  logic [NPIN-1:0] v2_irq_en,
    input  logic            sample_stb,
    input  logic            ack_v1,
    input  logic            ack_v2,
    output logic            pend_v1,
    output logic            pend_v2,
    output logic            wake,
    output logic            vec_valid,
    output logic [1:0]      vec_idx
);
    localparam int SW = NPIN + 1;

    logic [SW-1:0]   pins_s;
    logic            v2_edge;
    logic            p1, p2;
    vec_e            pick;

    eirq_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({v1_pin, v2_pins}),
        .dout (pins_s)
    );

    eirq_merge #(.NPIN(NPIN)) i_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (pins_s[NPIN-1:0]),
        .en      (v2_irq_en),
        .rise    (cfg_v2_rise),
        .edge_hit(v2_edge)
    );

    eirq_latch i_v2_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (v2_edge),
        .clr  (ack_v2),
        .kill (1'b0),
        .pend (p2)
    );

    eirq_v1 i_v1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (pins_s[NPIN]),
        .level_mode(cfg_v1_level),
        .strobe    (sample_stb),
        .ack       (ack_v1),
        .pend      (p1)
    );

    always_comb begin
        if (p1)      pick = VEC_ONE;
        else if (p2) pick = VEC_TWO;
        else         pick = VEC_NONE;
    end

    assign pend_v1   = p1;
    assign pend_v2   = p2;
    assign wake      = p1 | p2;
    assign vec_valid = cfg_gen & (p1 | p2);
    assign vec_idx   = pick;
endmodule

// File: rtl/eirq_ctrl_chk.sv
module eirq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_v1_level,
    input logic       sample_stb,
    input logic       ack_v1,
    input logic       ack_v2,
    input logic       v2_edge,
    input logic       pend_v1,
    input logic       pend_v2,
    input logic       vec_valid,
    input logic [1:0] vec_idx
);
    AST_V2_CLEAR_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_v2) |-> $past(ack_v2)); // R4

    AST_V2_SET_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_v2) |-> $past(v2_edge)); // R8

    AST_V1_EDGE_CLEAR_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_v1_level && $past(!cfg_v1_level) && $fell(pend_v1)) |-> $past(ack_v1)); // R4

    AST_V1_LEVEL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_v1_level && $past(cfg_v1_level) && !$stable(pend_v1)) |-> $past(sample_stb)); // R6

    AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_idx == 2'd1 || vec_idx == 2'd2)); // R2
endmodule

bind eirq_ctrl eirq_ctrl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_v1_level(cfg_v1_level),
    .sample_stb  (sample_stb),
    .ack_v1      (ack_v1),
    .ack_v2      (ack_v2),
    .v2_edge     (v2_edge),
    .pend_v1     (pend_v1),
    .pend_v2     (pend_v2),
    .vec_valid   (vec_valid),
    .vec_idx     (vec_idx)
);

// File: tb/test_eirq_ctrl.sv
`timescale 1ns/1ps
module test_eirq_ctrl;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_gen = 1'b1, cfg_v1_level = 1'b0, cfg_v2_rise = 1'b0;
    logic         v1_pin = 1'b1;
    logic [N-1:0] v2_pins = '1, v2_irq_en = '1;
    logic         sample_stb = 1'b0, ack_v1 = 1'b0, ack_v2 = 1'b0;
    logic         pend_v1, pend_v2, wake, vec_valid;
    logic [1:0]   vec_idx;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    bit e1 = 0, e2 = 0;

    always #2.5 clk = ~clk;

    eirq_ctrl #(.NPIN(N), .SYNC_STAGES(2)) i_eirq_ctrl (.*);

    function automatic bit act_of(logic [N-1:0] p, logic [N-1:0] en, logic r);
        logic [N-1:0] e;
        e = p | ~en;
        return r ? (|e) : ~(&e);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk({req, " pend_v1"}, pend_v1, e1);
        chk({req, " pend_v2"}, pend_v2, e2);
        chk({req, " wake R7"}, wake, e1 | e2);
        chk({req, " valid R1"}, vec_valid, cfg_gen & (e1 | e2));
        if (e1 | e2) chk({req, " idx R2"}, vec_idx, e1 ? 2'd1 : 2'd2);
    endtask

    task automatic pulse_ack1();
        ack_v1 = 1'b1; tick(1); ack_v1 = 1'b0; tick(1);
    endtask

    task automatic pulse_ack2();
        ack_v2 = 1'b1; tick(1); ack_v2 = 1'b0; tick(1);
    endtask

    task automatic pulse_stb();
        sample_stb = 1'b1; tick(1); sample_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=0 exp=1");
        finish_run();
    end

    initial begin
        logic [N-1:0] np;
        bit old_act;
        process::self().srandom(32'd1234);
        tick(3); rst_n = 1'b1; tick(5);
        chk_all("reset R1 R7");

        // R11 latency for a pin change
        v2_pins = 3'b110; tick(2);
        chk("R11 not yet", pend_v2, 1'b0);
        tick(1);
        chk("R11 at third edge", pend_v2, 1'b1);
        e2 = 1; chk_all("R2 R7 single v2");
        pulse_ack2(); e2 = 0; chk_all("R4 ack2");

        // R8 stuck pin blocks others
        v2_pins = 3'b100; tick(5); chk_all("R8 blocked");
        v2_pins = 3'b111; tick(5); chk_all("R8 release no edge");
        v2_pins = 3'b101; tick(5); e2 = 1; chk_all("R8 unblocked");
        pulse_ack2(); e2 = 0;

        // R5 one stored
        v2_pins = 3'b111; tick(5);
        v2_pins = 3'b011; tick(5); e2 = 1; chk_all("R5 first");
        v2_pins = 3'b111; tick(5);
        v2_pins = 3'b110; tick(5); chk_all("R5 second absorbed");
        pulse_ack2(); e2 = 0; chk_all("R5 single ack empties");
        v2_pins = 3'b111; tick(5);

        // R9 polarity toggle spurious, R11 config latency
        cfg_v2_rise = 1'b1; tick(1);
        chk("R9 R11 polarity spurious", pend_v2, 1'b1);
        e2 = 1; pulse_ack2(); e2 = 0;
        cfg_v2_rise = 1'b0; tick(5); chk_all("R9 back to falling no edge");

        // R10 enabling a low pin under falling polarity
        v2_irq_en = 3'b110; tick(5);
        v2_pins = 3'b110; tick(5); chk_all("R8 disabled pin ignored");
        v2_irq_en = 3'b111; tick(1);
        chk("R10 enable low pin", pend_v2, 1'b1);
        e2 = 1; pulse_ack2(); e2 = 0;

        // R10 disabling a low pin under rising polarity
        v2_pins = 3'b000; tick(5); chk_all("R10 setup");
        cfg_v2_rise = 1'b1; tick(5); chk_all("R9 rise on low line");
        v2_irq_en = 3'b110; tick(1);
        chk("R10 disable low pin rising", pend_v2, 1'b1);
        e2 = 1; pulse_ack2(); e2 = 0;
        cfg_v2_rise = 1'b0; tick(2);
        v2_irq_en = 3'b111; tick(2);
        v2_pins = 3'b111; tick(5); chk_all("R10 restore");

        // R3 vector 1 edge, R2 priority, R1 gen
        v1_pin = 1'b0; tick(5); e1 = 1; chk_all("R3 v1 falling");
        v2_pins = 3'b110; tick(5); e2 = 1; chk_all("R2 both pending");
        pulse_ack1(); e1 = 0; chk_all("R2 R4 v2 after ack1");
        cfg_gen = 1'b0; tick(1); chk_all("R1 R7 gen off");
        cfg_gen = 1'b1; tick(1);
        pulse_ack2(); e2 = 0;
        v1_pin = 1'b1; v2_pins = 3'b111; tick(5); chk_all("R3 rising ignored");

        // R6 level mode
        cfg_v1_level = 1'b1; tick(2);
        v1_pin = 1'b0; tick(5); chk_all("R6 no strobe");
        pulse_stb(); e1 = 1; chk_all("R6 strobe low");
        v1_pin = 1'b1; tick(5); chk_all("R6 held to next strobe");
        pulse_stb(); e1 = 0; chk_all("R6 strobe high");
        v1_pin = 1'b0; tick(5); v1_pin = 1'b1; tick(5);
        pulse_stb(); chk_all("R6 pulse between strobes lost");
        cfg_v1_level = 1'b0; tick(5); chk_all("R6 exit level");

        // random phase
        for (int s = 0; s < 400; s++) begin
            int kind;
            kind = $urandom_range(0, 6);
            case (kind)
                0: begin pulse_ack2(); e2 = 0; tick(3); end
                1: begin pulse_ack1(); e1 = 0; tick(3); end
                2: begin
                    np = N'($urandom);
                    old_act = act_of(v2_pins, v2_irq_en, cfg_v2_rise);
                    if (!old_act && act_of(np, v2_irq_en, cfg_v2_rise)) e2 = 1;
                    v2_pins = np; tick(5);
                end
                3: begin
                    np = N'($urandom);
                    old_act = act_of(v2_pins, v2_irq_en, cfg_v2_rise);
                    if (!old_act && act_of(v2_pins, np, cfg_v2_rise)) e2 = 1;
                    v2_irq_en = np; tick(5);
                end
                4: begin
                    old_act = act_of(v2_pins, v2_irq_en, cfg_v2_rise);
                    if (!old_act && act_of(v2_pins, v2_irq_en, ~cfg_v2_rise)) e2 = 1;
                    cfg_v2_rise = ~cfg_v2_rise; tick(5);
                end
                5: begin
                    logic nv;
                    nv = 1'($urandom);
                    if (v1_pin && !nv) e1 = 1;
                    v1_pin = nv; tick(5);
                end
                default: begin cfg_gen = 1'($urandom); tick(2); end
            endcase
            chk_all("R3 R8 R9 R10 random");
        end
        finish_run();
    end
endmodule